// File: doc/BRIEF.md
# Serial Programming Read Sequencer

This block sits on the host side of a two-wire synchronous programming link. It drives the link clock and a bidirectional data line, and it reads a run of bytes out of a target's nonvolatile memory. A client hands it a 22-bit start address and a byte count in a single request cycle. The block then steers the target's table pointer to that address using six core-instruction transfers. After that it repeats the read-with-post-increment transfer once per byte. Each returned byte is offered on a valid/ready output.

Every link transfer is 20 link clocks long: a 4-bit command followed by a 16-bit operand. For a read, the host stops driving the data line after the eighth operand clock. It then parks the clock low for a turnaround gap, and captures the byte that the target shifts back during the last eight clocks. The link clock half-period and the turnaround gap are parameters counted in system clock cycles. The address space is 0x000000 to 0x3FFFFF, which covers code, ID and configuration locations alike.

Top module: `prog_read_host`

## Requirements
- R1: During reset and whenever the block is idle, `busy`, `byteValid`, `linkClk` and `linkDataOe` are all low.
- R2: A cycle with `reqValid` high, `busy` low and a nonzero `reqCount` is accepted, and `busy` is high from the next cycle. A request with `reqCount` of zero, or any request made while `busy` is high, is ignored and causes no link activity.
- R3: Each transfer sends a 4-bit command and then a 16-bit operand, both least significant bit first, one bit per link clock, for 20 clocks in all. `linkDataOut` changes only in the cycle where `linkClk` rises, so it is stable while the clock is high and the target can latch it on the falling edge.
- R4: Each accepted request begins with exactly six transfers using command 0000 (core instruction). Their operands, with the opcode in bits 15:8 and the argument in bits 7:0, are in this order: 0x0E with {2'b00, addr[21:16]}; 0x6EF8; 0x0E with addr[15:8]; 0x6EF7; 0x0E with addr[7:0]; 0x6EF6.
- R5: After the pointer load, the block issues exactly `reqCount` transfers with command 1001 (read, post-increment) and does not reload the pointer. The bytes are delivered in ascending address order, wrapping modulo 2^22.
- R6: The host drives the data line (`linkDataOe` high) for all command clocks and operand clocks of core transfers, and for the first 8 operand clocks of a read, where it sends zeros. After the 12th falling edge of a read, `linkDataOe` goes low and stays low through the 8 data clocks. The clock stays low for at least TURN_GAP + HALF_PERIOD system cycles before the first data clock rises.
- R7: Returned bits are sampled on the falling edges of the 8 data clocks, least significant bit first. The byte is then shown on `byteData` with `byteValid` high, and both stay unchanged until a cycle with `byteReady` high.
- R8: While a byte waits on the output, the link is parked: `linkClk` and `linkDataOe` are low.
- R9: `busy` stays high until the handshake of the last byte and is low in the next cycle.
- R10: Each high phase and each low phase of `linkClk` lasts at least HALF_PERIOD system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 22 | Start address of the read |
| reqCount | input | CNT_W | Number of bytes to read |
| busy | output | 1 | High from acceptance until the last byte is taken |
| byteValid | output | 1 | A returned byte is available |
| byteReady | input | 1 | Client takes the byte |
| byteData | output | 8 | Returned byte |
| linkClk | output | 1 | Link clock to the target |
| linkDataOut | output | 1 | Data driven toward the target |
| linkDataOe | output | 1 | Output enable of the data line driver |
| linkDataIn | input | 1 | Data line as seen by the host |

## Verification
Two events can land in the same system cycle: the final byte handshake that ends a request, and a new request strobe from the client. The bench raises `reqValid` with a fresh address in exactly the cycle it raises `byteReady` for the last byte. That request must be dropped, so `busy` must be low one cycle later and no further link clock may appear. A second collision places a request strobe early in an active request, while the pointer load is under way. The bench judges that case from a model of the target: the model logs every transfer, and the log must hold only one pointer load and the expected number of reads.

// File: rtl/prog_read_pkg.sv
`timescale 1ns/1ps
package prog_read_pkg;

  localparam int ADDR_W    = 22;
  localparam int CMD_BITS  = 4;
  localparam int OPER_BITS = 16;
  localparam int XFER_BITS = CMD_BITS + OPER_BITS;

  // command codes, sent LSB first
  localparam logic [CMD_BITS-1:0] CMD_CORE     = 4'b0000;
  localparam logic [CMD_BITS-1:0] CMD_READ_INC = 4'b1001;

  // core instruction pieces used to steer the pointer
  localparam logic [7:0] OPC_LOAD_LIT = 8'h0E;
  localparam logic [7:0] OPC_STORE    = 8'h6E;
  localparam logic [7:0] PTR_TOP_REG  = 8'hF8;
  localparam logic [7:0] PTR_MID_REG  = 8'hF7;
  localparam logic [7:0] PTR_LOW_REG  = 8'hF6;

  // fall index (count before the edge) that ends a phase
  localparam logic [4:0] LAST_FALL     = 5'd19;
  localparam logic [4:0] PRE_TURN_FALL = 5'd11;

  typedef struct packed {
    logic loadWord;  // load next transfer word, clear fall count
    logic clkRun;    // let the link clock toggle
    logic oeOn;      // host drives the data line
    logic capture;   // shift returned bits in on falls
    logic turnRun;   // run the turnaround timer
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_TURN,
    ST_DATA,
    ST_DELIVER
  } seqState_t;

endpackage

// File: rtl/prog_read_dp.sv
`timescale 1ns/1ps
module prog_read_dp
  import prog_read_pkg::*;
#(
  parameter int HALF_PERIOD = 2,
  parameter int TURN_GAP    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic [XFER_BITS-1:0] txWord,
  input  logic                 linkDataIn,
  output logic                 linkClk,
  output logic                 linkDataOut,
  output logic                 linkDataOe,
  output logic                 fallEv,
  output logic [4:0]           fallCnt,
  output logic                 turnDone,
  output logic [7:0]           rxByte
);

  localparam int HC_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam int TG_W = (TURN_GAP > 1) ? $clog2(TURN_GAP) : 1;

  logic toggle;
  logic riseEv;
  logic clkQ;
  logic dataQ;
  logic oeQ;
  logic [XFER_BITS-1:0] txSh;
  logic [4:0] fallQ;
  logic [7:0] rxSh;
  logic [TG_W-1:0] turnCnt;

  // link clock divider: the parameter picks a counter or a direct toggle
  generate
    if (HALF_PERIOD == 1) begin : g_fast
      assign toggle = strb.clkRun;
    end else begin : g_div
      logic [HC_W-1:0] halfCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) halfCnt <= '0;
        else if (!strb.clkRun || toggle) halfCnt <= '0;
        else halfCnt <= halfCnt + 1'b1;
      end
      assign toggle = strb.clkRun && (halfCnt == HC_W'(HALF_PERIOD - 1));
    end
  endgenerate

  assign riseEv = toggle && !clkQ;
  assign fallEv = toggle && clkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkQ <= 1'b0;
    else if (toggle) clkQ <= ~clkQ;
  end

  // transmit: new bit leaves on each rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      dataQ <= 1'b0;
    end else if (strb.loadWord) begin
      txSh <= txWord;
    end else if (riseEv) begin
      dataQ <= txSh[0];
      txSh  <= txSh >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fallQ <= '0;
    else if (strb.loadWord) fallQ <= '0;
    else if (fallEv) fallQ <= fallQ + 5'd1;
  end

  // receive: LSB arrives first, so shift toward bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSh <= '0;
    else if (fallEv && strb.capture) rxSh <= {linkDataIn, rxSh[7:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) turnCnt <= '0;
    else if (!strb.turnRun) turnCnt <= '0;
    else if (!turnDone) turnCnt <= turnCnt + 1'b1;
  end
  assign turnDone = strb.turnRun && (turnCnt == TG_W'(TURN_GAP - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeQ <= 1'b0;
    else oeQ <= strb.oeOn;
  end

  assign linkClk     = clkQ;
  assign linkDataOut = dataQ;
  assign linkDataOe  = oeQ;
  assign fallCnt     = fallQ;
  assign rxByte      = rxSh;

endmodule

// File: rtl/prog_read_ctrl.sv
`timescale 1ns/1ps
module prog_read_ctrl
  import prog_read_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [CNT_W-1:0]     reqCount,
  input  logic                 byteReady,
  input  logic                 fallEv,
  input  logic [4:0]           fallCnt,
  input  logic                 turnDone,
  output seqStrobe_t           strb,
  output logic [XFER_BITS-1:0] txWord,
  output logic                 busy,
  output logic                 byteValid
);

  localparam logic [2:0] READ_STEP = 3'd6;

  seqState_t state;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  remainQ;
  logic [2:0]        stepQ;
  logic              isRead;
  logic [OPER_BITS-1:0] operand;
  logic [CMD_BITS-1:0]  cmd;

  assign isRead = (stepQ == READ_STEP);

  always_comb begin
    cmd = CMD_CORE;
    unique case (stepQ)
      3'd0:    operand = {OPC_LOAD_LIT, 2'b00, addrQ[21:16]};
      3'd1:    operand = {OPC_STORE, PTR_TOP_REG};
      3'd2:    operand = {OPC_LOAD_LIT, addrQ[15:8]};
      3'd3:    operand = {OPC_STORE, PTR_MID_REG};
      3'd4:    operand = {OPC_LOAD_LIT, addrQ[7:0]};
      3'd5:    operand = {OPC_STORE, PTR_LOW_REG};
      default: begin
        operand = '0;
        cmd     = CMD_READ_INC;
      end
    endcase
    txWord = {operand, cmd};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      addrQ   <= '0;
      remainQ <= '0;
      stepQ   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid && (reqCount != '0)) begin
          addrQ   <= reqAddr;
          remainQ <= reqCount;
          stepQ   <= '0;
          state   <= ST_LOAD;
        end
        ST_LOAD: state <= ST_SHIFT;
        ST_SHIFT: if (fallEv) begin
          if (isRead && fallCnt == PRE_TURN_FALL) begin
            state <= ST_TURN;
          end else if (!isRead && fallCnt == LAST_FALL) begin
            stepQ <= stepQ + 3'd1;
            state <= ST_LOAD;
          end
        end
        ST_TURN: if (turnDone) state <= ST_DATA;
        ST_DATA: if (fallEv && fallCnt == LAST_FALL) state <= ST_DELIVER;
        ST_DELIVER: if (byteReady) begin
          if (remainQ == CNT_W'(1)) begin
            state <= ST_IDLE;
          end else begin
            remainQ <= remainQ - 1'b1;
            state   <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadWord = (state == ST_LOAD);
    strb.clkRun   = (state == ST_SHIFT) || (state == ST_DATA);
    strb.oeOn     = (state == ST_LOAD) || (state == ST_SHIFT);
    strb.capture  = (state == ST_DATA);
    strb.turnRun  = (state == ST_TURN);
  end

  assign busy      = (state != ST_IDLE);
  assign byteValid = (state == ST_DELIVER);

endmodule

// File: rtl/prog_read_host.sv
`timescale 1ns/1ps
module prog_read_host
  import prog_read_pkg::*;
#(
  parameter int HALF_PERIOD = 2,
  parameter int TURN_GAP    = 4,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [21:0]      reqAddr,
  input  logic [CNT_W-1:0] reqCount,
  output logic             busy,
  output logic             byteValid,
  input  logic             byteReady,
  output logic [7:0]       byteData,
  output logic             linkClk,
  output logic             linkDataOut,
  output logic             linkDataOe,
  input  logic             linkDataIn
);

  seqStrobe_t           strb;
  logic [XFER_BITS-1:0] txWord;
  logic                 fallEv;
  logic [4:0]           fallCnt;
  logic                 turnDone;

  prog_read_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqCount(reqCount),
    .byteReady(byteReady),
    .fallEv(fallEv), .fallCnt(fallCnt), .turnDone(turnDone),
    .strb(strb), .txWord(txWord),
    .busy(busy), .byteValid(byteValid)
  );

  prog_read_dp #(.HALF_PERIOD(HALF_PERIOD), .TURN_GAP(TURN_GAP)) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .txWord(txWord), .linkDataIn(linkDataIn),
    .linkClk(linkClk), .linkDataOut(linkDataOut), .linkDataOe(linkDataOe),
    .fallEv(fallEv), .fallCnt(fallCnt), .turnDone(turnDone),
    .rxByte(byteData)
  );

endmodule

// File: rtl/prog_read_host_chk.sv
`timescale 1ns/1ps
module prog_read_host_chk #(
  parameter int HALF_PERIOD = 2,
  parameter int CNT_W       = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [CNT_W-1:0] reqCount,
  input logic             busy,
  input logic             byteValid,
  input logic             byteReady,
  input logic [7:0]       byteData,
  input logic             linkClk,
  input logic             linkDataOut,
  input logic             linkDataOe
);

  logic        clkPrev;
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      gap     <= 16'hFFFF;
    end else begin
      clkPrev <= linkClk;
      if (linkClk != clkPrev) gap <= '0;
      else if (gap != 16'hFFFF) gap <= gap + 16'd1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!linkClk && !linkDataOe && !byteValid));

  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqCount != '0) |=> busy);

  a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(reqValid && reqCount != '0)) |=> !busy);

  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (linkClk && $past(linkClk)) |-> $stable(linkDataOut));

  a_r8_parked_while_valid: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (!linkClk && !linkDataOe));

  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteReady) |=> (byteValid && $stable(byteData)));

  a_r9_busy_ends_on_handshake: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(byteValid && byteReady));

  a_r10_half_period: assert property (@(posedge clk) disable iff (!rstN)
    (linkClk != clkPrev) |-> (gap >= 16'(HALF_PERIOD - 1)));

endmodule

bind prog_read_host prog_read_host_chk #(.HALF_PERIOD(HALF_PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCount(reqCount),
  .busy(busy), .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData),
  .linkClk(linkClk), .linkDataOut(linkDataOut), .linkDataOe(linkDataOe)
);

// File: tb/test_prog_read_host.sv
`timescale 1ns/1ps
module test_prog_read_host;

  localparam int HALF = 2;
  localparam int TURN = 3;
  localparam int CW   = 8;
  localparam int PER  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic            reqValid = 1'b0;
  logic [21:0]     reqAddr = '0;
  logic [CW-1:0]   reqCount = '0;
  logic            byteReady = 1'b0;
  logic            busy, byteValid;
  logic [7:0]      byteData;
  logic            linkClk, linkDataOut, linkDataOe;
  logic            linkDataIn = 1'b0;

  int testCnt = 0;
  int failCnt = 0;

  prog_read_host #(.HALF_PERIOD(HALF), .TURN_GAP(TURN), .CNT_W(CW)) i_prog_read_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqCount(reqCount),
    .busy(busy), .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData),
    .linkClk(linkClk), .linkDataOut(linkDataOut), .linkDataOe(linkDataOe),
    .linkDataIn(linkDataIn)
  );

  function automatic logic [7:0] memByte(input logic [21:0] a);
    return ((a[7:0] * 8'd3) ^ a[15:8] ^ {2'b00, a[21:16]}) ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  logic [3:0]  curCmd = '0;
  logic [15:0] curOp = '0;
  int          fallIdx = 0;
  logic [21:0] tgtPtr = '0;
  logic [7:0]  tgtW = '0;
  logic [7:0]  tgtByte = '0;
  logic [3:0]  cmdLog [256];
  logic [15:0] opLog [256];
  int logCount = 0;
  int oeErr = 0, turnErr = 0, halfErr = 0;
  time riseT = 0, fallT = 0, turnT = 0;

  always @(negedge linkClk) begin
    if (rstN) begin
      if ($time - riseT < HALF * PER) halfErr++;
      fallT = $time;
      if (fallIdx < 4) curCmd[fallIdx] = linkDataOut;
      else if (!(curCmd == 4'b1001 && fallIdx >= 12)) curOp[fallIdx-4] = linkDataOut;
      if ((curCmd == 4'b1001 && fallIdx >= 12) ? linkDataOe : !linkDataOe) oeErr++;
      if (curCmd == 4'b1001 && fallIdx >= 4 && fallIdx < 12 && linkDataOut) oeErr++;
      if (fallIdx == 11 && curCmd == 4'b1001) begin
        tgtByte = memByte(tgtPtr);
        tgtPtr  = tgtPtr + 22'd1;
        turnT   = $time;
      end
      if (fallIdx == 19) begin
        if (curCmd == 4'b0000) begin
          if (curOp[15:8] == 8'h0E) tgtW = curOp[7:0];
          else if (curOp == 16'h6EF8) tgtPtr[21:16] = tgtW[5:0];
          else if (curOp == 16'h6EF7) tgtPtr[15:8] = tgtW;
          else if (curOp == 16'h6EF6) tgtPtr[7:0] = tgtW;
        end
        cmdLog[logCount % 256] = curCmd;
        opLog[logCount % 256]  = curOp;
        logCount++;
        fallIdx = 0;
      end else begin
        fallIdx++;
      end
    end
  end

  always @(posedge linkClk) begin
    if (rstN) begin
      if ($time - fallT < HALF * PER) halfErr++;
      riseT = $time;
      if (curCmd == 4'b1001 && fallIdx >= 12) begin
        if (fallIdx == 12 && ($time - turnT) < (TURN + HALF) * PER) turnErr++;
        linkDataIn = tgtByte[fallIdx-12];
      end
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && !byteValid && !linkClk && !linkDataOe, "R1", "outputs in reset",
          {busy, byteValid, linkClk, linkDataOe}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !byteValid && !linkClk && !linkDataOe, "R1", "outputs idle after reset",
          {busy, byteValid, linkClk, linkDataOe}, 0);
  endtask

  task automatic t_zero_count();
    int base = logCount;
    bit wasBusy = 0;
    @(negedge clk);
    reqAddr = 22'h001234; reqCount = '0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (40) begin
      if (busy || linkClk) wasBusy = 1;
      @(negedge clk);
    end
    check(!wasBusy, "R2", "zero count starts nothing", wasBusy, 0);
    check(logCount == base, "R2", "zero count transfers", logCount - base, 0);
  endtask

  task automatic t_read(input logic [21:0] addr, input int n, input int stall,
                        input bit pokeEarly, input bit pokeAtEnd);
    int base = logCount;
    int oe0 = oeErr, tu0 = turnErr, ha0 = halfErr;
    logic [7:0] got;
    bit held;
    @(negedge clk);
    reqAddr = addr; reqCount = CW'(n); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy, "R2", "busy after accept", busy, 1);
    if (pokeEarly) begin
      reqAddr = 22'h155555; reqCount = CW'(7); reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      while (!byteValid) @(negedge clk);
      got  = byteData;
      held = 1;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        if (!byteValid || byteData != got || linkClk || linkDataOe) held = 0;
      end
      if (stall > 0) check(held, "R7", "byte held while not ready (R8 link parked)", held, 1);
      check(got == memByte(addr + 22'(i)), "R5", "returned byte value",
            got, memByte(addr + 22'(i)));
      byteReady = 1'b1;
      if (pokeAtEnd && i == n - 1) begin
        reqAddr = 22'h0ABCDE; reqCount = CW'(2); reqValid = 1'b1;
      end
      @(negedge clk);
      byteReady = 1'b0;
      reqValid  = 1'b0;
    end
    check(!busy, "R9", "busy low one cycle after last handshake", busy, 0);
    repeat (60) @(negedge clk);
    check(!busy && logCount == base + 6 + n, "R2", "no extra activity after end",
          logCount - base, 6 + n);
    check(cmdLog[base % 256] == 4'b0000 && opLog[base % 256] == {8'h0E, 2'b00, addr[21:16]},
          "R4", "pointer step 0", opLog[base % 256], {8'h0E, 2'b00, addr[21:16]});
    check(cmdLog[(base+1) % 256] == 4'b0000 && opLog[(base+1) % 256] == 16'h6EF8,
          "R4", "pointer step 1", opLog[(base+1) % 256], 16'h6EF8);
    check(cmdLog[(base+2) % 256] == 4'b0000 && opLog[(base+2) % 256] == {8'h0E, addr[15:8]},
          "R4", "pointer step 2", opLog[(base+2) % 256], {8'h0E, addr[15:8]});
    check(cmdLog[(base+3) % 256] == 4'b0000 && opLog[(base+3) % 256] == 16'h6EF7,
          "R4", "pointer step 3", opLog[(base+3) % 256], 16'h6EF7);
    check(cmdLog[(base+4) % 256] == 4'b0000 && opLog[(base+4) % 256] == {8'h0E, addr[7:0]},
          "R4", "pointer step 4", opLog[(base+4) % 256], {8'h0E, addr[7:0]});
    check(cmdLog[(base+5) % 256] == 4'b0000 && opLog[(base+5) % 256] == 16'h6EF6,
          "R3", "pointer step 5 (LSB-first framing)", opLog[(base+5) % 256], 16'h6EF6);
    for (int j = 0; j < n; j++)
      check(cmdLog[(base+6+j) % 256] == 4'b1001, "R5", "read command code",
            cmdLog[(base+6+j) % 256], 4'b1001);
    check(oeErr == oe0, "R6", "data line drive ownership errors", oeErr - oe0, 0);
    check(turnErr == tu0, "R6", "turnaround gap errors", turnErr - tu0, 0);
    check(halfErr == ha0, "R10", "link clock phase length errors", halfErr - ha0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog R9: busy=%0d expected run to finish", busy);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    t_reset();
    t_read(22'h000000, 1, 0, 1'b0, 1'b0);
    t_read(22'h12ABCD, 4, 3, 1'b1, 1'b0);
    t_read(22'h3FFFFF, 2, 0, 1'b0, 1'b1);
    t_read(22'h2000FE, 3, 1, 1'b0, 1'b0);
    t_zero_count();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule